// File: doc/BRIEF.md
# Phase-Shifted Clock Output Generator

This block sits beside a module clock divider in the fast source-clock domain and derives two auxiliary clocks from the divided module clock: a drive clock for launching outgoing data and a sample clock for capturing incoming data. Each auxiliary clock has the same period and duty cycle as the module clock. Each one lags the module clock by a programmable whole number of source-clock periods. One source period corresponds to 360/D degrees, where D is the module divide ratio.

The divider supplies the divide ratio D and its phase count (0 to D-1). The module clock is high while the phase count is below floor(D/2). Both delay codes are held in one shared control register. Software can load that register as a whole word or update one code field at a time.

A delay code of zero does not mean zero shift. It selects the default half-period position, which is 180 degrees from the module clock. A new code takes effect only at the next module-clock period boundary, so an output never shows a clipped or stretched pulse. When the module clock gate is off, both outputs are held low.

Top module: `clk_phase_shifter`

## Requirements
- R1: While reset is asserted, `ctrl_q` reads 0 and both `drv_clk` and `smp_clk` are low. Because the register resets to 0, the default code for both outputs is 0.
- R2: A word write (`wr_en`) loads `wr_data` into `ctrl_q` on the next clock edge.
- R3: A field write (`fw_en`) clears a 4-bit span of `ctrl_q` and then puts `fw_code` in the two lowest bits of that span. The span starts at bit 8 when `fw_sel`=0 (drive code in bits 9:8) and at bit 20 when `fw_sel`=1 (sample code in bits 21:20). All other bits are unchanged. If a word write and a field write occur in the same cycle, the field write is applied on top of `wr_data`.
- R4: With code 0, the output is high in the phases p for which ((p - floor(D/2)) mod D) < floor(D/2). For even D, this is the exact inverse of the module clock.
- R5: With a nonzero code N < D, the output is high in the phases p for which ((p - N) mod D) < floor(D/2). This is the module clock delayed by N source periods.
- R6: When a nonzero code N is not smaller than D, the delay used is N mod D.
- R7: The outputs are registered. The value present in cycle t+1 reflects the phase count presented in cycle t.
- R8: The code used by an output is taken from `ctrl_q` only in a cycle whose phase count is 0. It is then held for the whole module-clock period, even if the register changes during that period.
- R9: In any cycle where `mod_en` is low, both outputs go low on the next edge.
- R10: The drive and sample outputs are independent. Each output uses only its own code field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock that feeds the module divider |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | Module divide ratio D, at least 2 |
| mod_phase | input | DIV_W | Divider phase count, 0 to D-1 |
| mod_en | input | 1 | Module clock gate enable |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | CTRL_W | Word write data |
| fw_en | input | 1 | Field write strobe |
| fw_sel | input | 1 | Field select: 0 selects the drive code, 1 selects the sample code |
| fw_code | input | CODE_W | Delay code for a field write |
| ctrl_q | output | CTRL_W | Shared control register |
| drv_clk | output | 1 | Delayed drive clock |
| smp_clk | output | 1 | Delayed sample clock |

## Verification
Two kinds of collision are targeted. The first is a word write and a field write in the same cycle. The bench provokes it by writing all ones together with a field update, then checks that the selected 4-bit span holds only the new code while every other bit holds the written word. The second is a code change landing in a phase-0 cycle compared with one landing mid-period. The bench issues field writes at several phase positions, including the cycle just before a wrap. A behavioural model then decides, for every source cycle, which code each output must be using, and the bench compares both outputs and the register against that model on every clock.

// File: rtl/clk_phase_shifter.sv
module clk_phase_shifter #(
  parameter int DIV_W   = 8,
  parameter int CTRL_W  = 32,
  parameter int CODE_W  = 2,
  parameter int SPAN_W  = 4,
  parameter int DRV_OFF = 8,
  parameter int SMP_OFF = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [DIV_W-1:0]  mod_phase,
  input  logic              mod_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              fw_en,
  input  logic              fw_sel,
  input  logic [CODE_W-1:0] fw_code,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              drv_clk,
  output logic              smp_clk
);

  localparam int NCH = 2;
  localparam logic [CTRL_W-1:0] SPAN_ONES = CTRL_W'({SPAN_W{1'b1}});
  localparam logic [CTRL_W-1:0] SPAN_MASK = (SPAN_ONES << DRV_OFF) | (SPAN_ONES << SMP_OFF);

  logic [CTRL_W-1:0] ctrl_d;
  logic [DIV_W-1:0]  half;
  logic [NCH-1:0]    outs;

  assign half = div_ratio >> 1;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
    if (fw_en) begin
      if (!fw_sel) begin
        ctrl_d[DRV_OFF +: SPAN_W] = '0;
        ctrl_d[DRV_OFF +: CODE_W] = fw_code;
      end else begin
        ctrl_d[SMP_OFF +: SPAN_W] = '0;
        ctrl_d[SMP_OFF +: CODE_W] = fw_code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int OFF = (g == 0) ? DRV_OFF : SMP_OFF;

    logic [CODE_W-1:0] act;
    logic [CODE_W-1:0] eff;
    logic [DIV_W-1:0]  code_x;
    logic [DIV_W-1:0]  shift;
    logic [DIV_W-1:0]  lag;
    logic              out_q;

    assign eff    = (mod_phase == '0) ? ctrl_q[OFF +: CODE_W] : act;
    assign code_x = DIV_W'(eff);
    assign shift  = (eff == '0) ? half :
                    (code_x >= div_ratio) ? code_x - div_ratio : code_x;
    assign lag    = (mod_phase >= shift) ? mod_phase - shift
                                         : mod_phase + div_ratio - shift;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act   <= '0;
        out_q <= 1'b0;
      end else begin
        act   <= eff;
        out_q <= mod_en && (lag < half);
      end
    end

    assign outs[g] = out_q;

    assert_field_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_en && (fw_sel == 1'(g))) |=> ctrl_q[OFF +: SPAN_W] == SPAN_W'($past(fw_code)));

    assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> !outs[g]);
  end

  assign drv_clk = outs[0];
  assign smp_clk = outs[1];

  assert_word_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fw_en) |=> ctrl_q == $past(wr_data));

  assert_spans_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (ctrl_q & ~SPAN_MASK) == ($past(ctrl_q) & ~SPAN_MASK));

  assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ratio >= DIV_W'(2)) && (mod_phase < div_ratio));

endmodule

// File: tb/clk_phase_shifter_tb_top.sv
module clk_phase_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_ratio, mod_phase;
  logic        mod_en, wr_en, fw_en, fw_sel;
  logic [31:0] wr_data, ctrl_q;
  logic [1:0]  fw_code;
  logic        drv_clk, smp_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_phase_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .mod_phase(mod_phase),
    .mod_en(mod_en), .wr_en(wr_en), .wr_data(wr_data), .fw_en(fw_en),
    .fw_sel(fw_sel), .fw_code(fw_code), .ctrl_q(ctrl_q),
    .drv_clk(drv_clk), .smp_clk(smp_clk));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic [31:0] m_ctrl;
  int m_act [2];
  logic m_out [2];
  int ph, dv;
  bit done = 0;
  int unsigned lfsr = 32'hACE1_2345;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] nc;
    int nact [2];
    logic nout [2];
    mod_phase = 8'(ph);
    div_ratio = 8'(dv);
    nc = m_ctrl;
    if (wr_en) nc = wr_data;
    if (fw_en) begin
      if (!fw_sel) begin nc[11:8] = 4'h0; nc[9:8] = fw_code; end
      else begin nc[23:20] = 4'h0; nc[21:20] = fw_code; end
    end
    for (int c = 0; c < 2; c++) begin
      int fld, e, s, x;
      fld = (c == 0) ? int'(m_ctrl[9:8]) : int'(m_ctrl[21:20]);
      e = (ph == 0) ? fld : m_act[c];
      nact[c] = e;
      s = (e == 0) ? dv / 2 : e % dv;
      x = (ph - s + dv) % dv;
      nout[c] = mod_en && (x < dv / 2);
    end
    @(posedge clk);
    @(negedge clk);
    check(fw_en ? "R3" : "R2", "ctrl_q", ctrl_q, nc);
    check(cur_req, "drv_clk R10", 32'(drv_clk), 32'(nout[0]));
    check(cur_req, "smp_clk R10", 32'(smp_clk), 32'(nout[1]));
    m_ctrl = nc;
    m_act = nact;
    m_out = nout;
    wr_en = 0; fw_en = 0;
    ph = (ph + 1) % dv;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic field(bit sel, logic [1:0] code);
    fw_en = 1; fw_sel = sel; fw_code = code;
    tick();
  endtask

  task automatic set_ratio(int d);
    while (ph != 0) tick();
    dv = d;
  endtask

  task automatic to_phase(int p);
    while (ph != p) tick();
  endtask

  initial begin
    rst_n = 0; div_ratio = 8; mod_phase = 0; mod_en = 1;
    wr_en = 0; wr_data = 0; fw_en = 0; fw_sel = 0; fw_code = 0;
    ph = 0; dv = 8;
    repeat (3) @(negedge clk);
    check("R1", "ctrl_q reset", ctrl_q, 32'h0);
    check("R1", "drv_clk reset", 32'(drv_clk), 32'h0);
    check("R1", "smp_clk reset", 32'(smp_clk), 32'h0);
    m_ctrl = 0; m_act = '{0, 0}; m_out = '{0, 0};
    rst_n = 1;

    cur_req = "R4"; run(32);
    cur_req = "R5"; field(0, 2'd1); field(1, 2'd3); run(40);
    cur_req = "R7"; set_ratio(4); run(24);
    cur_req = "R8";
    to_phase(2); field(0, 2'd2); run(6);
    to_phase(3); field(1, 2'd0); run(6);
    to_phase(dv - 1); field(0, 2'd3); run(10);
    cur_req = "R4"; set_ratio(5); field(0, 2'd0); field(1, 2'd0); run(30);
    cur_req = "R6"; set_ratio(2); field(0, 2'd3); field(1, 2'd2); run(20);
    set_ratio(3); field(0, 2'd3); run(20);
    cur_req = "R10"; set_ratio(7); field(0, 2'd2); field(1, 2'd1); run(28);
    cur_req = "R9";
    mod_en = 0; run(9); mod_en = 1; run(5); mod_en = 0; tick(); mod_en = 1; run(10);
    cur_req = "R3";
    wr_en = 1; wr_data = 32'hFFFF_FFFF; fw_en = 1; fw_sel = 0; fw_code = 2'd1; tick();
    wr_en = 1; wr_data = 32'h00F0_0F00; tick();
    field(1, 2'd2); field(0, 2'd0);
    wr_en = 1; wr_data = 32'h5A5A_A5A5; fw_en = 1; fw_sel = 1; fw_code = 2'd3; tick();
    run(16);
    cur_req = "R2";
    wr_en = 1; wr_data = 32'h0010_0200; tick(); run(16);
    cur_req = "R5";
    set_ratio(6);
    for (int i = 0; i < 600; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hD000_0001 : 32'h0);
      if (lfsr[4:0] == 0) begin fw_en = 1; fw_sel = lfsr[5]; fw_code = lfsr[7:6]; end
      if (lfsr[12:8] == 3) begin wr_en = 1; wr_data = lfsr; end
      mod_en = (lfsr[19:16] != 0);
      if (ph == dv - 1 && lfsr[23:21] == 0) begin
        tick();
        dv = 2 + int'(lfsr[27:24] % 9);
      end else tick();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule